// File: doc/BRIEF.md
# Flash command interface with bypass mode

This block models the command side of a parallel flash device. A host drives a simple bus with a select, a write strobe, a read strobe, an address and a data word. Writes are decoded as multi-cycle command sequences: single-word program, whole-chip erase, and entry into and exit from an unlock-bypass mode. In bypass mode a program takes only two writes. Accepted operations run on a small internal array (64 words of 16 bits in 4 blocks). A side-band input gives a protection bit per block.

While an operation runs, and while an error is held, every read returns a status word instead of array data. Read data is registered, so it appears on the output one cycle after the read strobe. Program and erase durations come from cycle-count parameters. There is a much shorter count for an erase in which every block is protected.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array word reads 0xFFFF, the device is in read mode, and the data for a read strobe appears on `rdData` one cycle after that strobe.
- R2: In normal mode, the writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by one write of address and data, start a program. It is busy for PROG_CYC cycles and leaves the word equal to its old value AND the data.
- R3: The writes 0xAA@0x555, 0x55@0x2AA and 0x20@0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by one address/data write performs the same program. Reads return array data.
- R4: In bypass mode, any write other than 0xA0 or 0x90 that begins a command is ignored. 0x90 followed by 0x00 returns to normal mode. 0x90 followed by anything else leaves the device in bypass mode.
- R5: A program whose data would need a 0 bit to become 1 ends in the error state. The stored word becomes old AND data. Reads return status with bit 7 = 1 and bit 5 = 1 until a write of 0xF0.
- R6: A program aimed at a word in a protected block leaves that word unchanged and ends in the same error state as R5. The block index is the address bits [5:4].
- R7: A 0xF0 write in the error state returns the device to read mode. If the error occurred in bypass mode, the device stays in bypass mode.
- R8: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and 0x10@0x555 start a chip erase. After ERASE_CYC cycles, every word of every unprotected block is 0xFFFF, protected blocks are unchanged, and no error is raised.
- R9: When all blocks are protected, a chip erase is busy for only SHORT_CYC cycles and leaves the data unchanged.
- R10: While an operation is busy, writes are ignored and cannot abort it. Every read returns status with bit 7 = 0 and bit 5 = 0. Bit 6 inverts on each such read.
- R11: A write that does not match the next expected step of a sequence returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Device select |
| wrEn | input | 1 | Write strobe (qualified by selIn) |
| rdEn | input | 1 | Read strobe (qualified by selIn) |
| addrIn | input | ADDR_W | Word address; the low 6 bits index the array |
| wrData | input | DATA_W | Write data; the low byte carries command codes |
| protIn | input | BLOCKS | Per-block protection, 1 = protected |
| rdData | output | DATA_W | Registered read data or status word |

## Verification
A write takes effect at the clock edge where it is sampled. An operation started at that edge is still busy for any read strobe sampled within the next PROG_CYC (or ERASE_CYC, or SHORT_CYC) edges, and is finished after that. Each read result is sampled on the falling edge after the edge that takes the read strobe. The bench therefore reads "immediately" to see busy status. It waits exactly SHORT_CYC cycles to separate the short erase from the full one, and waits the full count plus a margin before reading back array contents.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE_SU = 8'h80;
  localparam logic [7:0] CMD_CHIP_ERS = 8'h10;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_BYP_EXIT = 8'h90;
  localparam logic [7:0] CMD_BYP_ZERO = 8'h00;
  localparam logic [7:0] CMD_RESET    = 8'hF0;

  localparam int ADDR_UNLOCK_A = 'h555;
  localparam int ADDR_UNLOCK_B = 'h2AA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS1, SQ_ERS2, SQ_ERS3, SQ_BEXIT
  } seqState_t;

  typedef enum logic [1:0] { OP_IDLE, OP_BUSY, OP_ERR } opState_t;

  typedef struct packed {
    logic latchOp;      // capture address, data, protection at start
    logic commitProg;   // apply program on this edge
    logic commitErase;  // apply chip erase on this edge
    logic busyFlag;     // an operation is running
    logic errFlag;      // error held until reset command
  } ctlStrobe_t;

endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 64,
  parameter int BLOCKS = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int WPB_W = IDX_W - BLK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic              rdStrobe,
  input  logic [IDX_W-1:0]  addrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BLOCKS-1:0] protIn,
  output logic [DATA_W-1:0] rdData,
  output logic              progErr
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  latAddr;
  logic [DATA_W-1:0] latData;
  logic [BLOCKS-1:0] protLat;
  logic              toggleBit;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] statusWord;
  logic              protHit;

  assign curWord = mem[latAddr];
  assign protHit = protLat[latAddr[IDX_W-1 -: BLK_W]];
  assign progErr = protHit | (|(latData & ~curWord));

  always_comb begin
    statusWord    = '0;
    statusWord[7] = st.errFlag;
    statusWord[6] = toggleBit;
    statusWord[5] = st.errFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
      protLat <= '0;
    end else if (st.latchOp) begin
      latAddr <= addrIdx;
      latData <= wrData;
      protLat <= protIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (st.commitProg) begin
      if (!protHit) mem[latAddr] <= curWord & latData;
    end else if (st.commitErase) begin
      for (int i = 0; i < WORDS; i++)
        if (!protLat[i >> WPB_W]) mem[i] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      toggleBit <= 1'b0;
    end else if (rdStrobe) begin
      if (st.busyFlag || st.errFlag) rdData <= statusWord;
      else                           rdData <= mem[addrIdx];
      if (st.busyFlag) toggleBit <= ~toggleBit;
    end
  end

  // R2: an unprotected program can only clear bits
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitProg && !protHit) |=> ((curWord | latData) == latData));

  // R6: a protected target word is left as it was
  p_prot_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitProg && protHit) |=> (curWord == $past(curWord)));

  // R10: reads while busy show the not-ready, no-error status
  p_busy_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && st.busyFlag) |=> (rdData[7] == 1'b0 && rdData[5] == 1'b0));

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int BLOCKS    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int SHORT_CYC = 3,
  localparam int CNT_W = $clog2(ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        cmd,
  input  logic [BLOCKS-1:0] protIn,
  input  logic              progErr,
  output ctlStrobe_t        st
);

  seqState_t        seqState;
  opState_t         opState;
  logic             bypassMode;
  logic             isErase;
  logic [CNT_W-1:0] cnt;
  logic             atA, atB, startProg, startErase, finishOp;

  assign atA = (addrIn == ADDR_W'(ADDR_UNLOCK_A));
  assign atB = (addrIn == ADDR_W'(ADDR_UNLOCK_B));
  assign startProg  = wrStrobe && opState == OP_IDLE && seqState == SQ_PROG;
  assign startErase = wrStrobe && opState == OP_IDLE && !bypassMode &&
                      seqState == SQ_ERS3 && atA && cmd == CMD_CHIP_ERS;
  assign finishOp   = opState == OP_BUSY && cnt == '0;

  always_comb begin
    st             = '0;
    st.latchOp     = startProg | startErase;
    st.commitProg  = finishOp && !isErase;
    st.commitErase = finishOp && isErase;
    st.busyFlag    = opState == OP_BUSY;
    st.errFlag     = opState == OP_ERR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState   <= SQ_IDLE;
      opState    <= OP_IDLE;
      bypassMode <= 1'b0;
      isErase    <= 1'b0;
      cnt        <= '0;
    end else begin
      case (opState)
        OP_BUSY: begin
          if (finishOp) opState <= (!isErase && progErr) ? OP_ERR : OP_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        OP_ERR: begin
          if (wrStrobe && cmd == CMD_RESET) opState <= OP_IDLE;
        end
        default: begin
          if (startProg) begin
            opState  <= OP_BUSY;
            isErase  <= 1'b0;
            cnt      <= CNT_W'(PROG_CYC - 1);
            seqState <= SQ_IDLE;
          end else if (startErase) begin
            opState  <= OP_BUSY;
            isErase  <= 1'b1;
            cnt      <= (&protIn) ? CNT_W'(SHORT_CYC - 1) : CNT_W'(ERASE_CYC - 1);
            seqState <= SQ_IDLE;
          end else if (wrStrobe && bypassMode) begin
            seqState <= SQ_IDLE;
            case (seqState)
              SQ_IDLE: begin
                if (cmd == CMD_PROGRAM)       seqState <= SQ_PROG;
                else if (cmd == CMD_BYP_EXIT) seqState <= SQ_BEXIT;
              end
              SQ_BEXIT: if (cmd == CMD_BYP_ZERO) bypassMode <= 1'b0;
              default: ;
            endcase
          end else if (wrStrobe) begin
            seqState <= SQ_IDLE;
            case (seqState)
              SQ_IDLE: if (atA && cmd == CMD_UNLOCK_A) seqState <= SQ_UNL1;
              SQ_UNL1: if (atB && cmd == CMD_UNLOCK_B) seqState <= SQ_UNL2;
              SQ_UNL2: begin
                if (atA && cmd == CMD_PROGRAM)       seqState <= SQ_PROG;
                else if (atA && cmd == CMD_ERASE_SU) seqState <= SQ_ERS1;
                else if (atA && cmd == CMD_BYPASS)   bypassMode <= 1'b1;
              end
              SQ_ERS1: if (atA && cmd == CMD_UNLOCK_A) seqState <= SQ_ERS2;
              SQ_ERS2: if (atB && cmd == CMD_UNLOCK_B) seqState <= SQ_ERS3;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R10: a running operation cannot be aborted; its count only runs down
  p_no_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_BUSY && cnt != '0) |=> (opState == OP_BUSY && cnt == $past(cnt) - 1'b1));

  // R5: the error state is left only through the reset command
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ERR && !(wrStrobe && cmd == CMD_RESET)) |=> opState == OP_ERR);

  // R7: clearing an error does not change the mode
  p_mode_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ERR) |=> $stable(bypassMode));

  // R8: start and commit strobes never coincide
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.latchOp, st.commitProg, st.commitErase}));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int WORDS     = 64,
  parameter int BLOCKS    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int SHORT_CYC = 3,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BLOCKS-1:0] protIn,
  output logic [DATA_W-1:0] rdData
);

  ctlStrobe_t strobes;
  logic       progErr;
  logic       wrStrobe, rdStrobe;

  assign wrStrobe = selIn & wrEn;
  assign rdStrobe = selIn & rdEn;

  flash_cmd_ctl #(
    .ADDR_W(ADDR_W), .BLOCKS(BLOCKS), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .SHORT_CYC(SHORT_CYC)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addrIn(addrIn),
    .cmd(wrData[7:0]), .protIn(protIn), .progErr(progErr), .st(strobes)
  );

  flash_cmd_dp #(
    .DATA_W(DATA_W), .WORDS(WORDS), .BLOCKS(BLOCKS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .rdStrobe(rdStrobe),
    .addrIdx(addrIn[IDX_W-1:0]), .wrData(wrData), .protIn(protIn),
    .rdData(rdData), .progErr(progErr)
  );

endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 40;
  localparam int SHORT_CYC = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selIn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [10:0] addrIn = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  protIn = '0;
  logic [15:0] rdData;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  flash_cmd_if #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SHORT_CYC(SHORT_CYC))
    i_flash_cmd_if (.clk(clk), .rstN(rstN), .selIn(selIn), .wrEn(wrEn), .rdEn(rdEn),
                    .addrIn(addrIn), .wrData(wrData), .protIn(protIn), .rdData(rdData));

  // kind: 0 write, 1 read and compare, 2 wait d cycles
  typedef struct packed { logic [1:0] kind; logic [10:0] a; logic [15:0] d; } vec_t;
  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 11'h555, 16'h00AA}, '{2'd0, 11'h2AA, 16'h0055}, '{2'd0, 11'h555, 16'h00A0},
    '{2'd0, 11'h005, 16'h1234}, '{2'd2, 11'h000, 16'(PROG_CYC + 2)},
    '{2'd1, 11'h005, 16'h1234}, '{2'd1, 11'h006, 16'hFFFF},
    '{2'd0, 11'h555, 16'h00AA}, '{2'd0, 11'h2AA, 16'h0055}, '{2'd0, 11'h555, 16'h00A0},
    '{2'd0, 11'h005, 16'h1030}, '{2'd2, 11'h000, 16'(PROG_CYC + 2)},
    '{2'd1, 11'h005, 16'h1030},
    '{2'd0, 11'h555, 16'h00AA}, '{2'd0, 11'h2AA, 16'h0055}, '{2'd0, 11'h555, 16'h00A0}
  };

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); selIn = 1'b1; wrEn = 1'b1; addrIn = a; wrData = d;
    @(negedge clk); selIn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] v);
    @(negedge clk); selIn = 1'b1; rdEn = 1'b1; addrIn = a;
    @(negedge clk); selIn = 1'b0; rdEn = 1'b0; v = rdData;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [10:0] a, input logic [15:0] mask,
                       input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v & mask, exp);
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
  endtask

  task automatic chipErase();
    unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h555, 16'h0010);
  endtask

  localparam logic [15:0] M_NOTGL = 16'hFFBF;
  localparam logic [15:0] ST_ERR  = 16'h00A0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    logic [15:0] v1, v2;
    waitc(3);
    rstN = 1'b1;
    waitc(1);

    // R1: reset state, registered read
    rdchk("R1 word0", 11'h000, 16'hFFFF, 16'hFFFF);
    rdchk("R1 word63", 11'h03F, 16'hFFFF, 16'hFFFF);

    // R2: vector table of normal programs
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].kind)
        2'd0: wr(VECS[i].a, VECS[i].d);
        2'd1: rdchk("R2 table", VECS[i].a, 16'hFFFF, VECS[i].d);
        default: waitc(int'(VECS[i].d));
      endcase
    end
    wr(11'h021, 16'h00FF);           // completes the last table sequence
    // R10: busy status and toggle, writes during busy ignored
    rd(11'h021, v1);
    check("R10 busy status", v1 & M_NOTGL, 16'h0000);
    rd(11'h021, v2);
    check("R10 toggle", v1[6] ^ v2[6], 16'h0001);
    unlock(); wr(11'h555, 16'h00A0);
    waitc(PROG_CYC);
    rdchk("R2 program 0x21", 11'h021, 16'hFFFF, 16'h00FF);
    wr(11'h011, 16'h0000);
    rdchk("R10 writes while busy ignored", 11'h011, 16'hFFFF, 16'hFFFF);

    // R11: broken sequence
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0);
    wr(11'h012, 16'h0000);
    rdchk("R11 broken sequence", 11'h012, 16'hFFFF, 16'hFFFF);

    // R5: 0-to-1 program error
    unlock(); wr(11'h555, 16'h00A0); wr(11'h005, 16'h1234);
    waitc(PROG_CYC + 2);
    rdchk("R5 error status", 11'h005, M_NOTGL, ST_ERR);
    rdchk("R5 error on other address", 11'h030, M_NOTGL, ST_ERR);
    wr(11'h555, 16'h00A0);
    rdchk("R5 error held", 11'h005, M_NOTGL, ST_ERR);
    wr(11'h000, 16'h00F0);
    rdchk("R5 bits only cleared", 11'h005, 16'hFFFF, 16'h1030);

    // R3: bypass entry and bypass program
    unlock(); wr(11'h555, 16'h0020);
    rdchk("R3 bypass reads array", 11'h005, 16'hFFFF, 16'h1030);
    wr(11'h7FF, 16'h00A0); wr(11'h013, 16'h5555);
    waitc(PROG_CYC + 2);
    rdchk("R3 bypass program", 11'h013, 16'hFFFF, 16'h5555);

    // R4: other commands ignored in bypass
    wr(11'h555, 16'h0080); chipErase();
    waitc(ERASE_CYC + 2);
    rdchk("R4 erase ignored in bypass", 11'h013, 16'hFFFF, 16'h5555);
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0055);
    wr(11'h000, 16'h00A0); wr(11'h014, 16'h0F0F);
    waitc(PROG_CYC + 2);
    rdchk("R4 bad exit keeps bypass", 11'h014, 16'hFFFF, 16'h0F0F);

    // R6 and R7: protected program inside bypass
    protIn = 4'b0010;
    wr(11'h000, 16'h00A0); wr(11'h013, 16'h0000);
    waitc(PROG_CYC + 2);
    rdchk("R6 protected program status", 11'h013, M_NOTGL, ST_ERR);
    wr(11'h000, 16'h00F0);
    rdchk("R6 protected word unchanged", 11'h013, 16'hFFFF, 16'h5555);
    wr(11'h000, 16'h00A0); wr(11'h030, 16'h7777);
    waitc(PROG_CYC + 2);
    rdchk("R7 bypass kept after clear", 11'h030, 16'hFFFF, 16'h7777);

    // R4: exit bypass
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0); wr(11'h031, 16'h0000);
    waitc(PROG_CYC + 2);
    rdchk("R4 exit to normal mode", 11'h031, 16'hFFFF, 16'hFFFF);

    // R8: partial chip erase with block 1 protected
    chipErase();
    rdchk("R8 busy during erase", 11'h005, M_NOTGL, 16'h0000);
    waitc(SHORT_CYC);
    rdchk("R8 still busy after short count", 11'h005, M_NOTGL, 16'h0000);
    wr(11'h000, 16'h00F0); unlock(); wr(11'h555, 16'h00A0);
    wr(11'h032, 16'h0000);
    waitc(ERASE_CYC + 2);
    rdchk("R8 block0 erased", 11'h005, 16'hFFFF, 16'hFFFF);
    rdchk("R8 block1 protected", 11'h013, 16'hFFFF, 16'h5555);
    rdchk("R8 block2 erased", 11'h021, 16'hFFFF, 16'hFFFF);
    rdchk("R8 block3 erased", 11'h030, 16'hFFFF, 16'hFFFF);
    rdchk("R10 program during erase ignored", 11'h032, 16'hFFFF, 16'hFFFF);

    // R9: all blocks protected
    protIn = 4'b0000;
    unlock(); wr(11'h555, 16'h00A0); wr(11'h002, 16'h1111);
    waitc(PROG_CYC + 2);
    protIn = 4'b1111;
    chipErase();
    waitc(SHORT_CYC);
    rdchk("R9 short erase data kept", 11'h002, 16'hFFFF, 16'h1111);
    rdchk("R9 protected block1 kept", 11'h013, 16'hFFFF, 16'h5555);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule